// File: doc/BRIEF.md
# Display Panel Boot Splash Sequencer

This block is a hardware sequencer that brings up a small colour display module and puts a boot picture on it, with no processor involved. The panel is reached over an 8-bit parallel bus. A write strobe is active low. A separate select line tells the panel whether the byte on the bus is a command or a data byte. The block also drives the panel's chip select, its active-low reset line and its backlight enable.

A one-cycle pulse on `start` runs the bring-up. The order is fixed: select the panel, pulse its reset line, paint the whole 128x128 frame with one 16-bit colour, set a column and row window, and stream a fixed-size picture into that window. The picture comes from an external byte ROM, read through an address/data port with a one-cycle read latency. When the last byte has left the bus, the backlight turns on and `done` pulses.

The states are IDLE, RST_HI1, RST_LO, RST_HI2, CLR_CMD, CLR_DAT, COL_CMD, COL_D0, COL_D1, ROW_CMD, ROW_D0, ROW_D1, IMG_CMD, IMG_DAT, FLUSH, DONE and SHOW. The transitions are:

- IDLE or SHOW goes to RST_HI1 on `start`.
- Each of RST_HI1, RST_LO and RST_HI2 lasts `RST_CYCLES` cycles, then moves on to the next.
- Every write state advances when the bus writer accepts its byte.
- CLR_DAT and IMG_DAT repeat until their last byte is accepted.
- FLUSH waits until the bus writer is idle.
- DONE lasts one cycle and then goes to SHOW.

Top module: `splash_seq`

## Requirements
- R1: After system reset the outputs are: `pnl_cs_n`=1, `pnl_rst_n`=1, `pnl_wr_n`=1, `pnl_dc`=1, `pnl_bl_en`=0 and `done`=0.
- R2: The first clock edge with `start`=1 in IDLE or SHOW starts the reset pulse. From that edge, `pnl_rst_n` is 1 for `RST_CYCLES` cycles, then 0 for `RST_CYCLES` cycles, then 1 for `RST_CYCLES` cycles. `pnl_cs_n` is 0 throughout, and no write strobe occurs during the pulse.
- R3: Each byte takes three cycles. In the setup cycle, data and `pnl_dc` are driven with `pnl_wr_n`=1. In the strobe cycle, `pnl_wr_n`=0 for exactly one cycle. In the hold cycle, `pnl_wr_n`=1 with data and `pnl_dc` unchanged.
- R4: `pnl_dc` is 0 only during the setup, strobe and hold cycles of a command byte. It is 1 in every other cycle, including the cycle right after a command.
- R5: The first byte written is command 0x2C. It is followed by 32768 data bytes that alternate between 0xFC and 0xC0, high byte first (colour 0xFCC0).
- R6: Next come command 0x2A with data 0x36 then 0x49, and then command 0x2B with data 0x2E then 0x51.
- R7: Next come command 0x2C and 1440 data bytes equal to ROM bytes 0 to 1439 in address order. A ROM byte appears on `img_data` one clock after its address is on `img_addr`.
- R8: `pnl_bl_en` stays 0 during every write. It rises exactly three cycles after the strobe of the final image byte, in the same cycle as a single-cycle `done` pulse.
- R9: `start` is ignored while the sequence is running. The bytes and the `done` count are unchanged by it.
- R10: After completion, `pnl_bl_en` stays 1 and `pnl_cs_n` stays 0 until a new `start`. A new `start` drops the backlight and repeats the whole sequence from R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| start | input | 1 | Begin the bring-up sequence |
| done | output | 1 | One-cycle pulse when the backlight turns on |
| pnl_cs_n | output | 1 | Panel chip select, active low |
| pnl_rst_n | output | 1 | Panel reset, active low |
| pnl_dc | output | 1 | 0 = command byte, 1 = data byte |
| pnl_wr_n | output | 1 | Write strobe, active low |
| pnl_d | output | 8 | Panel data bus |
| pnl_bl_en | output | 1 | Backlight enable, active high |
| img_addr | output | ADDR_W (11) | Image ROM byte address |
| img_data | input | 8 | Image ROM byte, one cycle after the address |

## Verification
The image ROM model returns a byte that depends on its address in a non-linear way. A single-cycle slip in address timing, or a skipped or repeated byte, therefore shows up as a content mismatch rather than passing unnoticed. The fill colour uses two different bytes, so swapping the high and low halves of the pixel order gives a visible error. A `start` pulse is injected in the middle of the clear stream to tell an ignored restart apart from one that re-enters the reset pulse. A second `start` after completion checks that a finished sequence can be re-run, and that the backlight drops again before the new reset pulse.

// File: rtl/splash_pkg.sv
package splash_pkg;

    typedef enum logic [4:0] {
        S_IDLE,
        S_RST_HI1,
        S_RST_LO,
        S_RST_HI2,
        S_CLR_CMD,
        S_CLR_DAT,
        S_COL_CMD,
        S_COL_D0,
        S_COL_D1,
        S_ROW_CMD,
        S_ROW_D0,
        S_ROW_D1,
        S_IMG_CMD,
        S_IMG_DAT,
        S_FLUSH,
        S_DONE,
        S_SHOW
    } seq_state_e;

    typedef enum logic [1:0] {
        WP_IDLE,
        WP_SETUP,
        WP_STROBE,
        WP_HOLD
    } wr_phase_e;

    localparam logic [7:0] OP_MEM_WRITE = 8'h2C;
    localparam logic [7:0] OP_COL_WIN   = 8'h2A;
    localparam logic [7:0] OP_ROW_WIN   = 8'h2B;

endpackage

// File: rtl/splash_bus_wr.sv
module splash_bus_wr
    import splash_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_dc,
    input  logic [DW-1:0] req_data,
    output logic          take,
    output logic          idle,
    output logic          wr_n,
    output logic          dc,
    output logic [DW-1:0] d
);

    wr_phase_e     phase_q;
    logic [DW-1:0] data_q;
    logic          dc_q;

    // A new byte may be loaded from an idle bus or from the hold cycle of the previous byte
    assign take = req && (phase_q == WP_IDLE || phase_q == WP_HOLD);
    assign idle = (phase_q == WP_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= WP_IDLE;
            data_q  <= '0;
            dc_q    <= 1'b1;
        end else if (take) begin
            phase_q <= WP_SETUP;
            data_q  <= req_data;
            dc_q    <= req_dc;
        end else begin
            unique case (phase_q)
                WP_IDLE:   phase_q <= WP_IDLE;
                WP_SETUP:  phase_q <= WP_STROBE;
                WP_STROBE: phase_q <= WP_HOLD;
                WP_HOLD: begin
                    phase_q <= WP_IDLE;
                    dc_q    <= 1'b1;
                end
                default:   phase_q <= WP_IDLE;
            endcase
        end
    end

    assign wr_n = (phase_q != WP_STROBE);
    assign dc   = dc_q;
    assign d    = data_q;

endmodule

// File: rtl/splash_delay.sv
module splash_delay #(
    parameter int unsigned LIMIT = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    if (LIMIT <= 1) begin : g_pass
        assign expired = run;
    end else begin : g_cnt
        localparam int unsigned TW = $clog2(LIMIT);
        logic [TW-1:0] cnt_q;

        assign expired = run && (cnt_q == TW'(LIMIT - 1));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (!run || expired) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/splash_count.sv
module splash_count #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] value
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (clr) begin
            value <= '0;
        end else if (inc) begin
            value <= value + 1'b1;
        end
    end

endmodule

// File: rtl/splash_seq.sv
module splash_seq
    import splash_pkg::*;
#(
    parameter int unsigned PANEL_W    = 128,
    parameter int unsigned PANEL_H    = 128,
    parameter int unsigned IMG_BYTES  = 1440,
    parameter int unsigned RST_CYCLES = 250,
    parameter logic [15:0] FILL_COLOR = 16'hFCC0,
    parameter logic [7:0]  COL_FIRST  = 8'h36,
    parameter logic [7:0]  COL_LAST   = 8'h49,
    parameter logic [7:0]  ROW_FIRST  = 8'h2E,
    parameter logic [7:0]  ROW_LAST   = 8'h51,
    localparam int unsigned ADDR_W    = $clog2(IMG_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              done,
    output logic              pnl_cs_n,
    output logic              pnl_rst_n,
    output logic              pnl_dc,
    output logic              pnl_wr_n,
    output logic [7:0]        pnl_d,
    output logic              pnl_bl_en,
    output logic [ADDR_W-1:0] img_addr,
    input  logic [7:0]        img_data
);

    localparam int unsigned FILL_BYTES = PANEL_W * PANEL_H * 2;
    localparam int unsigned CNT_TOP    = (FILL_BYTES > IMG_BYTES) ? FILL_BYTES : IMG_BYTES;
    localparam int unsigned CNT_W      = $clog2(CNT_TOP + 1);

    seq_state_e state_q, state_d;

    logic             req, req_dc, take, wr_idle;
    logic [7:0]       req_data;
    logic             tmr_run, tmr_exp;
    logic             cnt_clr;
    logic [CNT_W-1:0] cnt_q;
    logic             fill_last, img_last;

    assign fill_last = (cnt_q == CNT_W'(FILL_BYTES - 1));
    assign img_last  = (cnt_q == CNT_W'(IMG_BYTES - 1));

    splash_bus_wr #(.DW(8)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .req_dc   (req_dc),
        .req_data (req_data),
        .take     (take),
        .idle     (wr_idle),
        .wr_n     (pnl_wr_n),
        .dc       (pnl_dc),
        .d        (pnl_d)
    );

    splash_delay #(.LIMIT(RST_CYCLES)) u_dly (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmr_run),
        .expired (tmr_exp)
    );

    splash_count #(.CW(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (take),
        .value (cnt_q)
    );

    // The byte counter is also the image address of the next byte still to be sent
    assign img_addr = cnt_q[ADDR_W-1:0];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start)   state_d = S_RST_HI1;
            S_RST_HI1: if (tmr_exp) state_d = S_RST_LO;
            S_RST_LO:  if (tmr_exp) state_d = S_RST_HI2;
            S_RST_HI2: if (tmr_exp) state_d = S_CLR_CMD;
            S_CLR_CMD: if (take)    state_d = S_CLR_DAT;
            S_CLR_DAT: if (take && fill_last) state_d = S_COL_CMD;
            S_COL_CMD: if (take)    state_d = S_COL_D0;
            S_COL_D0:  if (take)    state_d = S_COL_D1;
            S_COL_D1:  if (take)    state_d = S_ROW_CMD;
            S_ROW_CMD: if (take)    state_d = S_ROW_D0;
            S_ROW_D0:  if (take)    state_d = S_ROW_D1;
            S_ROW_D1:  if (take)    state_d = S_IMG_CMD;
            S_IMG_CMD: if (take)    state_d = S_IMG_DAT;
            S_IMG_DAT: if (take && img_last) state_d = S_FLUSH;
            S_FLUSH:   if (wr_idle) state_d = S_DONE;
            S_DONE:                 state_d = S_SHOW;
            S_SHOW:    if (start)   state_d = S_RST_HI1;
            default:                state_d = S_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        req       = 1'b0;
        req_dc    = 1'b1;
        req_data  = 8'h00;
        tmr_run   = 1'b0;
        cnt_clr   = 1'b1;
        pnl_cs_n  = 1'b0;
        pnl_rst_n = 1'b1;
        pnl_bl_en = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            S_IDLE:    pnl_cs_n = 1'b1;
            S_RST_HI1: tmr_run = 1'b1;
            S_RST_LO: begin
                tmr_run   = 1'b1;
                pnl_rst_n = 1'b0;
            end
            S_RST_HI2: tmr_run = 1'b1;
            S_CLR_CMD: begin
                req      = 1'b1;
                req_dc   = 1'b0;
                req_data = OP_MEM_WRITE;
            end
            S_CLR_DAT: begin
                req      = 1'b1;
                cnt_clr  = 1'b0;
                req_data = cnt_q[0] ? FILL_COLOR[7:0] : FILL_COLOR[15:8];
            end
            S_COL_CMD: begin
                req      = 1'b1;
                req_dc   = 1'b0;
                req_data = OP_COL_WIN;
            end
            S_COL_D0: begin
                req      = 1'b1;
                req_data = COL_FIRST;
            end
            S_COL_D1: begin
                req      = 1'b1;
                req_data = COL_LAST;
            end
            S_ROW_CMD: begin
                req      = 1'b1;
                req_dc   = 1'b0;
                req_data = OP_ROW_WIN;
            end
            S_ROW_D0: begin
                req      = 1'b1;
                req_data = ROW_FIRST;
            end
            S_ROW_D1: begin
                req      = 1'b1;
                req_data = ROW_LAST;
            end
            S_IMG_CMD: begin
                req      = 1'b1;
                req_dc   = 1'b0;
                req_data = OP_MEM_WRITE;
            end
            S_IMG_DAT: begin
                req      = 1'b1;
                cnt_clr  = 1'b0;
                req_data = img_data;
            end
            S_FLUSH:   ;
            S_DONE: begin
                pnl_bl_en = 1'b1;
                done      = 1'b1;
            end
            S_SHOW:    pnl_bl_en = 1'b1;
            default:   pnl_cs_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/splash_seq_chk.sv
module splash_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       done,
    input logic       pnl_cs_n,
    input logic       pnl_rst_n,
    input logic       pnl_dc,
    input logic       pnl_wr_n,
    input logic [7:0] pnl_d,
    input logic       pnl_bl_en
);

    // R2: panel reset only while selected and with the bus quiet
    assert_rst_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pnl_rst_n |-> (!pnl_cs_n && pnl_wr_n));

    // R3: strobe lasts a single cycle
    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pnl_wr_n |=> pnl_wr_n);

    // R3: setup cycle before the strobe with unchanged bus
    assert_setup_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pnl_wr_n |-> ($past(pnl_wr_n) && $stable(pnl_d) && $stable(pnl_dc)));

    // R3: hold cycle after the strobe with unchanged bus
    assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pnl_wr_n) |-> ($stable(pnl_d) && $stable(pnl_dc)));

    // R4: a command select lasts setup, strobe and hold, then returns high
    assert_cmd_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pnl_dc) |-> pnl_wr_n ##1 (!pnl_wr_n && !pnl_dc) ##1 (pnl_wr_n && !pnl_dc) ##1 pnl_dc);

    // R8: no write while the backlight is on, and every write is selected and out of reset
    assert_write_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pnl_wr_n |-> (!pnl_cs_n && !pnl_bl_en && pnl_rst_n));

    // R8: the backlight only rises together with done
    assert_bl_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pnl_bl_en) |-> done);

    // R8: done is a one-cycle pulse
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind splash_seq splash_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .pnl_cs_n  (pnl_cs_n),
    .pnl_rst_n (pnl_rst_n),
    .pnl_dc    (pnl_dc),
    .pnl_wr_n  (pnl_wr_n),
    .pnl_d     (pnl_d),
    .pnl_bl_en (pnl_bl_en)
);

// File: tb/tb_splash_seq.sv
`timescale 1ns/1ps
module tb_splash_seq;

    localparam int W     = 24;
    localparam int IMG_N = 1440;
    localparam int AW    = $clog2(IMG_N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          done;
    logic          pnl_cs_n, pnl_rst_n, pnl_dc, pnl_wr_n, pnl_bl_en;
    logic [7:0]    pnl_d;
    logic [AW-1:0] img_addr;
    logic [7:0]    img_data = 8'h00;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int writes_seen = 0;
    int done_cnt = 0;
    int last_strobe = -100;
    bit mon_en = 1'b0;
    bit prev_wr_n = 1'b1;
    bit prev_dc = 1'b1;
    logic [7:0] prev_d = 8'h00;

    bit         exp_dc[$];
    logic [7:0] exp_d[$];
    string      exp_tag[$];

    always #2.5 clk = ~clk;

    splash_seq #(.RST_CYCLES(W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .done      (done),
        .pnl_cs_n  (pnl_cs_n),
        .pnl_rst_n (pnl_rst_n),
        .pnl_dc    (pnl_dc),
        .pnl_wr_n  (pnl_wr_n),
        .pnl_d     (pnl_d),
        .pnl_bl_en (pnl_bl_en),
        .img_addr  (img_addr),
        .img_data  (img_data)
    );

    function automatic logic [7:0] rom_f(input int a);
        return 8'((a * 37) ^ (a >> 3) ^ 8'h5A);
    endfunction

    // Image ROM model with one-cycle latency
    always @(posedge clk) img_data <= rom_f(int'(img_addr));

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input bit dc, input logic [7:0] d, input string tag);
        exp_dc.push_back(dc);
        exp_d.push_back(d);
        exp_tag.push_back(tag);
    endtask

    task automatic build_run();
        push(1'b0, 8'h2C, "R5");
        for (int i = 0; i < 16384; i++) begin
            push(1'b1, 8'hFC, "R5");
            push(1'b1, 8'hC0, "R5");
        end
        push(1'b0, 8'h2A, "R6");
        push(1'b1, 8'h36, "R6");
        push(1'b1, 8'h49, "R6");
        push(1'b0, 8'h2B, "R6");
        push(1'b1, 8'h2E, "R6");
        push(1'b1, 8'h51, "R6");
        push(1'b0, 8'h2C, "R7");
        for (int i = 0; i < IMG_N; i++) push(1'b1, rom_f(i), "R7");
    endtask

    // Reference comparison on every clock
    always @(negedge clk) begin
        cyc++;
        if (rst_n && mon_en) begin
            if (!pnl_wr_n) begin
                chk(prev_wr_n && prev_d == pnl_d && prev_dc == pnl_dc, "R3", "setup before strobe",
                    {pnl_dc, pnl_d}, {prev_dc, prev_d});
                if (exp_d.size() == 0) begin
                    chk(1'b0, "R5", "unexpected write", {pnl_dc, pnl_d}, 0);
                end else begin
                    chk(pnl_dc == exp_dc[0] && pnl_d == exp_d[0], exp_tag[0], "byte {dc,data}",
                        {pnl_dc, pnl_d}, {exp_dc[0], exp_d[0]});
                    void'(exp_dc.pop_front());
                    void'(exp_d.pop_front());
                    void'(exp_tag.pop_front());
                end
                chk(!pnl_bl_en, "R8", "backlight during write", pnl_bl_en, 0);
                last_strobe = cyc;
                writes_seen++;
            end
            if (!prev_wr_n) begin
                chk(pnl_wr_n && pnl_d == prev_d && pnl_dc == prev_dc, "R3", "hold after strobe",
                    {pnl_wr_n, pnl_dc, pnl_d}, {1'b1, prev_dc, prev_d});
                // R4: a command select must not outlast its hold cycle
            end
            if (done) begin
                done_cnt++;
                chk(exp_d.size() == 0, "R7", "bytes left at done", exp_d.size(), 0);
                chk(cyc - last_strobe == 3, "R8", "done delay after last strobe", cyc - last_strobe, 3);
                chk(pnl_bl_en == 1'b1, "R8", "backlight at done", pnl_bl_en, 1);
                chk(pnl_dc == 1'b1, "R4", "select idle level", pnl_dc, 1);
            end
        end
        prev_wr_n = pnl_wr_n;
        prev_dc   = pnl_dc;
        prev_d    = pnl_d;
    end

    // Checks the reset pulse starting at the current negedge sample
    task automatic check_reset_pulse(input string tag);
        int bad = 0;
        int bad_cs = 0;
        for (int k = 0; k < 3 * W; k++) begin
            bit exp_r = !(k >= W && k < 2 * W);
            if (pnl_rst_n != exp_r || !pnl_wr_n) bad++;
            if (pnl_cs_n || pnl_bl_en) bad_cs++;
            @(negedge clk);
        end
        chk(bad == 0, "R2", {tag, " reset pulse shape"}, bad, 0);
        chk(bad_cs == 0, "R2", {tag, " select held, backlight off"}, bad_cs, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(pnl_cs_n == 1'b1, "R1", "cs_n after reset", pnl_cs_n, 1);
        chk(pnl_rst_n == 1'b1 && pnl_wr_n == 1'b1, "R1", "rst_n/wr_n after reset",
            {pnl_rst_n, pnl_wr_n}, 2'b11);
        chk(pnl_dc == 1'b1, "R1", "dc after reset", pnl_dc, 1);
        chk(pnl_bl_en == 1'b0 && done == 1'b0, "R1", "bl/done after reset", {pnl_bl_en, done}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(pnl_cs_n == 1'b1 && pnl_wr_n == 1'b1, "R1", "idle without start", {pnl_cs_n, pnl_wr_n}, 2'b11);

        build_run();
        mon_en = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_reset_pulse("first run");

        // R9: a start in mid-stream must be ignored
        wait (writes_seen >= 500);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(pnl_rst_n == 1'b1 && pnl_cs_n == 1'b0, "R9", "no restart while busy", {pnl_rst_n, pnl_cs_n}, 2'b10);

        while (done_cnt == 0) @(negedge clk);
        chk(writes_seen == 34216, "R9", "byte total with busy start", writes_seen, 34216);

        repeat (20) @(negedge clk);
        chk(done_cnt == 1, "R9", "done count", done_cnt, 1);
        chk(pnl_bl_en == 1'b1 && pnl_cs_n == 1'b0, "R10", "backlight and select held after finish",
            {pnl_bl_en, pnl_cs_n}, 2'b10);
        chk(pnl_wr_n == 1'b1 && pnl_dc == 1'b1, "R4", "bus idle after finish", {pnl_wr_n, pnl_dc}, 2'b11);

        // R10: a new start reruns the sequence
        build_run();
        writes_seen = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(pnl_bl_en == 1'b0, "R10", "backlight off on restart", pnl_bl_en, 0);
        check_reset_pulse("second run");
        wait (writes_seen >= 12);
        repeat (3) @(negedge clk);
        chk(done_cnt == 1, "R10", "no early done in second run", done_cnt, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule